// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt requests of a small processor core and turns them into a single request line plus a 16-bit vector address. Eleven request inputs are ranked by fixed priority. A twelfth slot, the highest, belongs to reset. Reset is not routed through the request logic: the synchronous reset input clears every pending and in-service flag directly. The power-down request always bypasses the mask. The block ANDs every other request with a per-source mask bit and selects the highest-priority survivor. The vector map is not monotonic: the power-down source is second in priority, yet its vector is numerically the highest.

The core drives the block through single-cycle strobes: mask write, control write, force/clear write, global enable, global disable, acknowledge and return-from-interrupt. The control register holds a nesting enable and the edge/level choice for three programmable pins. Two pins are always level-sensitive. The power-down input, one fixed pin and the peripheral requests are always edge-captured. An acknowledge marks the presented source as in service and clears its edge latch. A return strobe retires the highest-priority in-service entry.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Request bit i (1..11) has priority i, where a lower index wins. The presented vectors are: bit 1 → 0x002C, bit 2 → 0x0004, bit 3 → 0x0008, bit 4 → 0x000C, bit 5 → 0x0010, bit 6 → 0x0014, bit 7 → 0x0018, bit 8 → 0x001C, bit 9 → 0x0020, bit 10 → 0x0024, bit 11 → 0x0028. `irq_vec` is 0 whenever `irq` is low.
- R2: A source in bits 2..11 can be presented only while its `mask_wdata` bit (same index, 1 = enabled) is set in the mask register. Bit 1 (power-down) ignores the mask.
- R3: In the cycle that follows any mask write, `irq` is low. The next cycle is governed by the new mask.
- R4: The control register layout is: bit 1 selects edge sensing (1) or level sensing (0) for source 2, bit 2 does so for source 9, and bit 3 for source 10. Sources 3 and 4 are always level-sensitive. Sources 1, 5, 6, 7, 8 and 11 are always edge-sensitive (rising edge).
- R5: A captured edge stays pending after its input falls, until that source is acknowledged. A level source is never latched, so it is seen for exactly as long as its input is high.
- R6: A force/clear write sets the pending latch of each edge-mode source whose bit is set in `fc_wdata[11:0]`. It clears the latch of each source whose bit is set in `fc_wdata[23:12]`, and clear wins when both are set. Neither half has any effect on level-mode sources.
- R7: `gie_clr` blocks all presentation, power-down included, until `gie_set`. Servicing is enabled out of reset.
- R8: When control bit 0 (nesting) is 1, only a source of strictly higher priority than the highest-priority in-service entry is presented. When it is 0, nothing is presented while any entry is in service.
- R9: `rti` clears the highest-priority in-service entry.
- R10: After reset, `irq` is 0 and `irq_vec` is 0. The mask, control and pending state are all zero, and nothing is in service. An input that is already high at release is not taken as an edge.
- R11: An `ack` while `irq` is low changes neither pending nor in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the highest-priority source |
| req_in | input | 11 | Request lines, bit i = priority i (bits 11:1) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | New mask, bit i enables source i |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Bit 0 nesting, bits 3:1 edge select for sources 10, 9, 2 |
| fc_we | input | 1 | Force/clear write strobe |
| fc_wdata | input | 24 | Force bits [11:0], clear bits [23:12] |
| gie_set | input | 1 | Global enable strobe |
| gie_clr | input | 1 | Global disable strobe (wins over set) |
| ack | input | 1 | Core accepts the presented vector |
| rti | input | 1 | Core returns from the current handler |
| irq | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the presented source |

## Verification
The bench sweeps every pair of sources so that priority and the vector map are checked together. A design that sorted by vector value would put power-down last, and the sweep would catch it. It walks each source through a mask that excludes only that source. This shows whether the power-down exemption exists and whether any other source leaks through its mask. It probes the blackout cycle right after a mask write, where a missing or overlong blackout shows up as a wrong `irq` on one exact cycle. It also runs a nested sequence of acknowledges and returns. A design that compared against the wrong in-service entry, or retired the wrong one, would present a lower-priority vector too early or stay silent.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants and per-source decode helpers for the interrupt
// controller. Assumes a fixed twelve-entry map where index = priority.
package irq_prio_pkg;
    localparam int NSRC   = 12;
    localparam int VEC_W  = 16;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int CTRL_W = 4;
    localparam int NPROG  = 3;
    localparam int CTRL_NEST = 0;
    localparam logic [NSRC-1:0] NONMASK = NSRC'(3);

    typedef enum logic [1:0] {SENSE_NONE, SENSE_LEVEL, SENSE_EDGE, SENSE_PROG} sense_e;

    // Sensing kind of each priority slot.
    function automatic sense_e sense_of(int i);
        case (i)
            0:        return SENSE_NONE;
            3, 4:     return SENSE_LEVEL;
            2, 9, 10: return SENSE_PROG;
            default:  return SENSE_EDGE;
        endcase
    endfunction

    // Which programmable-sense control bit (0..NPROG-1) a slot uses.
    function automatic int prog_sel_of(int i);
        case (i)
            9:       return 1;
            10:      return 2;
            default: return 0;
        endcase
    endfunction

    // Vector address of a slot; slot 1 sits past all the others.
    function automatic logic [VEC_W-1:0] vector_of(int i);
        if (i == 0)      return '0;
        else if (i == 1) return VEC_W'((NSRC - 1) * 4);
        else             return VEC_W'((i - 1) * 4);
    endfunction
endpackage

// File: rtl/irq_sense.sv
// Module: request sensing. Captures rising edges into pending latches for
// edge-mode slots and passes level-mode slots straight through.
// Assumes inputs are synchronous to clk; slot 0 is never a request.
module irq_sense
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req,
    input  logic [NPROG-1:0] prog_edge,
    input  logic [NSRC-1:0]  force_set,
    input  logic [NSRC-1:0]  force_clr,
    input  logic [NSRC-1:0]  ack_hit,
    output logic [NSRC-1:0]  pend_eff
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] edge_mode;
    logic [NSRC-1:0] level_mode;
    logic [NSRC-1:0] rise;

    // Per-slot sensing mode chosen by the slot's fixed kind.
    for (genvar i = 0; i < NSRC; i++) begin : g_mode
        localparam sense_e KIND = sense_of(i);
        if (KIND == SENSE_LEVEL) begin : g_lvl
            assign edge_mode[i]  = 1'b0;
            assign level_mode[i] = 1'b1;
        end else if (KIND == SENSE_EDGE) begin : g_edg
            assign edge_mode[i]  = 1'b1;
            assign level_mode[i] = 1'b0;
        end else if (KIND == SENSE_PROG) begin : g_prg
            assign edge_mode[i]  = prog_edge[prog_sel_of(i)];
            assign level_mode[i] = ~prog_edge[prog_sel_of(i)];
        end else begin : g_none
            assign edge_mode[i]  = 1'b0;
            assign level_mode[i] = 1'b0;
        end
    end

    assign rise = req & ~prev_q;

    // Edge history and pending latches; clear beats force, ack, and edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
            pend_q <= '0;
        end else begin
            prev_q <= req;
            pend_q <= ((pend_q & ~ack_hit) | rise | force_set) & ~force_clr & edge_mode;
        end
    end

    // Effective request per slot as seen by the selector.
    always_comb begin
        pend_eff = (pend_q & edge_mode) | (req & level_mode);
    end
endmodule

// File: rtl/irq_service.sv
// Module: in-service tracking. Sets the acknowledged slot, retires the
// highest-priority entry on return, and derives which slots may preempt.
// Assumes ack_hit is one-hot or zero.
module irq_service
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nest_en,
    input  logic [NSRC-1:0] ack_hit,
    input  logic            rti,
    output logic [NSRC-1:0] isr_q,
    output logic [NSRC-1:0] allow
);
    logic [NSRC-1:0] top;

    // Lowest set index = highest-priority handler in progress.
    always_comb begin
        top = isr_q & (~isr_q + NSRC'(1));
    end

    // In-service register update on return and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (rti ? (isr_q & ~top) : isr_q) | ack_hit;
        end
    end

    // Slots allowed to be presented given nesting mode.
    always_comb begin
        if (nest_en) allow = top - NSRC'(1);
        else         allow = {NSRC{isr_q == '0}};
    end
endmodule

// File: rtl/irq_select.sv
// Module: priority selection. Picks the lowest-index candidate and its
// vector. Purely combinational; assumes slot 0 is never a candidate.
module irq_select
    import irq_prio_pkg::*;
(
    input  logic [NSRC-1:0]  cand,
    output logic             any,
    output logic [NSRC-1:0]  win_oh,
    output logic [VEC_W-1:0] vec
);
    logic [IDX_W-1:0] idx;

    // Priority encoder, lowest index wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (cand[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

    // One-hot winner and vector lookup.
    always_comb begin
        win_oh = any ? (NSRC'(1) << idx) : '0;
        vec    = vector_of(int'(idx));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized vectored interrupt controller. Holds the
// mask, control and global-enable registers and the post-mask-write
// blackout, and joins sensing, service tracking and selection.
// Assumes all strobes are single-cycle and synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:1]     req_in,
    input  logic                mask_we,
    input  logic [NSRC-1:0]     mask_wdata,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                fc_we,
    input  logic [2*NSRC-1:0]   fc_wdata,
    input  logic                gie_set,
    input  logic                gie_clr,
    input  logic                ack,
    input  logic                rti,
    output logic                irq,
    output logic [VEC_W-1:0]    irq_vec
);
    logic [NSRC-1:0]   mask_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              gie_q;
    logic              blk_q;
    logic              nest_en;
    logic [NSRC-1:0]   force_set;
    logic [NSRC-1:0]   force_clr;
    logic [NSRC-1:0]   pend_eff;
    logic [NSRC-1:0]   ack_hit;
    logic [NSRC-1:0]   isr_q;
    logic [NSRC-1:0]   allow;
    logic [NSRC-1:0]   cand;
    logic              any;
    logic [NSRC-1:0]   win_oh;
    logic [VEC_W-1:0]  sel_vec;

    // Software-visible registers and the one-cycle blackout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
            gie_q  <= 1'b1;
            blk_q  <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (ctrl_we) ctrl_q <= ctrl_wdata;
            if (gie_clr)      gie_q <= 1'b0;
            else if (gie_set) gie_q <= 1'b1;
            blk_q <= mask_we;
        end
    end

    // Split the force/clear word into its halves, gated by the strobe.
    always_comb begin
        force_set = fc_we ? fc_wdata[NSRC-1:0]      : '0;
        force_clr = fc_we ? fc_wdata[2*NSRC-1:NSRC] : '0;
        nest_en   = ctrl_q[CTRL_NEST];
    end

    irq_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       ({req_in, 1'b0}),
        .prog_edge (ctrl_q[CTRL_W-1:1]),
        .force_set (force_set),
        .force_clr (force_clr),
        .ack_hit   (ack_hit),
        .pend_eff  (pend_eff)
    );

    irq_service u_service (
        .clk     (clk),
        .rst_n   (rst_n),
        .nest_en (nest_en),
        .ack_hit (ack_hit),
        .rti     (rti),
        .isr_q   (isr_q),
        .allow   (allow)
    );

    // Candidate set after mask and nesting filter.
    always_comb begin
        cand = pend_eff & (mask_q | NONMASK) & allow;
    end

    irq_select u_select (
        .cand   (cand),
        .any    (any),
        .win_oh (win_oh),
        .vec    (sel_vec)
    );

    // Request gating by global enable and blackout; ack only when presented.
    always_comb begin
        irq     = gie_q & ~blk_q & any;
        irq_vec = irq ? sel_vec : '0;
        ack_hit = (ack && irq) ? win_oh : '0;
    end
endmodule

// File: rtl/irq_prio_chk.sv
// Module: assertion checker for irq_prio_ctrl, bound into every instance.
// Assumes it sees the top's ports and its in-service register.
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mask_we,
    input logic             gie_clr,
    input logic             rti,
    input logic             irq,
    input logic [VEC_W-1:0] irq_vec,
    input logic [NSRC-1:0]  isr_q,
    input logic             nest_en,
    input logic [NSRC-1:0]  ack_hit
);
    assert_vec_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec[1:0] == 2'b00 && irq_vec != '0 && irq_vec <= VEC_W'((NSRC - 1) * 4)));

    assert_blackout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> !irq);

    assert_single_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

    assert_gie_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !irq);

    assert_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && isr_q != '0) |-> !irq);

    assert_rti_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && ack_hit == '0 && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind irq_prio_ctrl irq_prio_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .gie_clr (gie_clr),
    .rti     (rti),
    .irq     (irq),
    .irq_vec (irq_vec),
    .isr_q   (isr_q),
    .nest_en (nest_en),
    .ack_hit (ack_hit)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:1] req_in = '0;
    logic        mask_we = 1'b0;
    logic [11:0] mask_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [3:0]  ctrl_wdata = '0;
    logic        fc_we = 1'b0;
    logic [23:0] fc_wdata = '0;
    logic        gie_set = 1'b0;
    logic        gie_clr = 1'b0;
    logic        ack = 1'b0;
    logic        rti = 1'b0;
    logic        irq;
    logic [15:0] irq_vec;

    int checks = 0;
    int errors = 0;
    localparam logic [11:0] LEVEL_AT_RESET = 12'h61C;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .fc_we(fc_we), .fc_wdata(fc_wdata),
        .gie_set(gie_set), .gie_clr(gie_clr),
        .ack(ack), .rti(rti), .irq(irq), .irq_vec(irq_vec)
    );

    function automatic logic [15:0] exp_vec(int i);
        case (i)
            1: return 16'h002C;  2: return 16'h0004;  3: return 16'h0008;
            4: return 16'h000C;  5: return 16'h0010;  6: return 16'h0014;
            7: return 16'h0018;  8: return 16'h001C;  9: return 16'h0020;
            10: return 16'h0024; 11: return 16'h0028;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; req_in = '0; mask_we = 0; ctrl_we = 0; fc_we = 0;
        gie_set = 0; gie_clr = 0; ack = 0; rti = 0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    task automatic wr_mask(logic [11:0] m);
        mask_wdata = m; mask_we = 1'b1; tick; mask_we = 1'b0; tick;
    endtask

    task automatic wr_ctrl(logic [3:0] c);
        ctrl_wdata = c; ctrl_we = 1'b1; tick; ctrl_we = 1'b0;
    endtask

    task automatic wr_fc(logic [11:0] f, logic [11:0] c);
        fc_wdata = {c, f}; fc_we = 1'b1; tick; fc_we = 1'b0;
    endtask

    task automatic p_ack;  ack = 1'b1; tick; ack = 1'b0; endtask
    task automatic p_rti;  rti = 1'b1; tick; rti = 1'b0; endtask
    task automatic p_set;  gie_set = 1'b1; tick; gie_set = 1'b0; endtask
    task automatic p_clr;  gie_clr = 1'b1; tick; gie_clr = 1'b0; endtask

    // Raise a set of sources with control at reset value.
    task automatic apply_set(logic [11:0] s);
        req_in = s[11:1] & LEVEL_AT_RESET[11:1];
        wr_fc(s & ~LEVEL_AT_RESET, 12'h000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state with every input already high
        rst_n = 1'b0; req_in = '1; tick; tick; rst_n = 1'b1;
        chk("R10 irq", {15'b0, irq}, 16'h0);
        chk("R10 vec", irq_vec, 16'h0);
        tick;
        chk("R10 no edge", {15'b0, irq}, 16'h0);
        wr_mask(12'hFFF);
        chk("R10 level seen after mask", irq_vec, exp_vec(2));

        // R1: every pair of sources, full mask
        for (int i = 1; i <= 11; i++) begin
            for (int j = i; j <= 11; j++) begin
                do_reset;
                wr_mask(12'hFFF);
                apply_set((12'h1 << i) | (12'h1 << j));
                chk($sformatf("R1 pair %0d,%0d", i, j), irq_vec, exp_vec(i));
            end
        end

        // R2: mask excludes only the raised source
        for (int i = 1; i <= 11; i++) begin
            do_reset;
            wr_mask(~(12'h1 << i));
            apply_set(12'h1 << i);
            chk($sformatf("R2 masked %0d", i), {15'b0, irq}, (i == 1) ? 16'h1 : 16'h0);
            wr_mask(12'h1 << i);
            chk($sformatf("R2 enabled %0d", i), irq_vec, exp_vec(i));
        end

        // R3: blackout cycle after a mask write
        do_reset;
        wr_mask(12'hFFF);
        wr_fc(12'h020, 12'h000);
        chk("R3 before", irq_vec, exp_vec(5));
        mask_wdata = 12'hFFF; mask_we = 1'b1; tick; mask_we = 1'b0;
        chk("R3 blackout", {15'b0, irq}, 16'h0);
        tick;
        chk("R3 after", irq_vec, exp_vec(5));

        // R4: programmable pins in both modes
        for (int p = 0; p < 3; p++) begin
            int s;
            s = (p == 0) ? 2 : (p == 1) ? 9 : 10;
            do_reset;
            wr_mask(12'hFFF);
            req_in[s] = 1'b1; tick;
            chk($sformatf("R4 level hi %0d", s), irq_vec, exp_vec(s));
            req_in[s] = 1'b0; tick;
            chk($sformatf("R4 level lo %0d", s), {15'b0, irq}, 16'h0);
            wr_ctrl(4'b0010 << p);
            req_in[s] = 1'b1; tick; req_in[s] = 1'b0; tick;
            chk($sformatf("R4 edge held %0d", s), irq_vec, exp_vec(s));
        end
        // R4: fixed pins unaffected by control
        do_reset;
        wr_mask(12'hFFF);
        wr_ctrl(4'b1110);
        req_in[3] = 1'b1; tick; req_in[3] = 1'b0; tick;
        chk("R4 fixed level 3", {15'b0, irq}, 16'h0);
        req_in[7] = 1'b1; tick; req_in[7] = 1'b0; tick;
        chk("R4 fixed edge 7", irq_vec, exp_vec(7));

        // R5: edge cleared by ack, level persists
        p_ack;
        chk("R5 in service", {15'b0, irq}, 16'h0);
        p_rti;
        chk("R5 edge cleared", {15'b0, irq}, 16'h0);
        req_in[4] = 1'b1; tick;
        p_ack; p_rti;
        chk("R5 level persists", irq_vec, exp_vec(4));
        req_in[4] = 1'b0; tick;
        chk("R5 level gone", {15'b0, irq}, 16'h0);

        // R6: force and clear
        do_reset;
        wr_mask(12'hFFF);
        wr_fc(12'h040, 12'h000);
        chk("R6 force", irq_vec, exp_vec(6));
        wr_fc(12'h000, 12'h040);
        chk("R6 clear", {15'b0, irq}, 16'h0);
        wr_fc(12'h100, 12'h100);
        chk("R6 clear wins", {15'b0, irq}, 16'h0);
        wr_fc(12'h01C, 12'h000);
        chk("R6 level ignores force", {15'b0, irq}, 16'h0);

        // R7 and R11: global disable, ignored ack
        do_reset;
        wr_mask(12'hFFF);
        p_clr;
        wr_fc(12'h042, 12'h000);
        chk("R7 disabled", {15'b0, irq}, 16'h0);
        p_ack;
        p_set;
        chk("R11 ack ignored / R7 pd wins", irq_vec, exp_vec(1));
        p_ack;
        p_rti;
        chk("R11 pending kept", irq_vec, exp_vec(6));

        // R8 and R9: nested service
        do_reset;
        wr_mask(12'hFFF);
        wr_ctrl(4'b0001);
        wr_fc(12'h100, 12'h000);
        chk("R8 first", irq_vec, exp_vec(8));
        p_ack;
        wr_fc(12'h800, 12'h000);
        chk("R8 lower held", {15'b0, irq}, 16'h0);
        wr_fc(12'h020, 12'h000);
        chk("R8 higher preempts", irq_vec, exp_vec(5));
        p_ack;
        wr_fc(12'h040, 12'h000);
        chk("R8 between held", {15'b0, irq}, 16'h0);
        p_rti;
        chk("R9 retire top", irq_vec, exp_vec(6));
        p_ack; p_rti;
        chk("R9 back to 8", {15'b0, irq}, 16'h0);
        p_rti;
        chk("R9 empty", irq_vec, exp_vec(11));
        // R8: no nesting blocks even higher priority
        do_reset;
        wr_mask(12'hFFF);
        wr_fc(12'h100, 12'h000);
        p_ack;
        wr_fc(12'h020, 12'h000);
        chk("R8 serial", {15'b0, irq}, 16'h0);
        p_rti;
        chk("R8 serial release", irq_vec, exp_vec(5));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule